// File: doc/BRIEF.md
# Saturating Signed Adder-Subtractor

This block adds or subtracts two two's-complement integers in a single combinational path. Next to the wrapped sum it gives the raw carry-out, a signed overflow flag and a clamped result. The clamped result pins to the largest positive or the most negative representable value when saturation is enabled and the true result does not fit. It also orders the two operands as signed numbers: it drives less-than, greater-than and equal flags, and it selects the minimum and the maximum. This makes it a drop-in arithmetic stage for fixed-width feedback-control datapaths.

Either operand may be narrower than the result width. A narrower operand is widened by copying its sign bit, so negative values keep their meaning. The raw sum and carry-out do not depend on any signed interpretation, so the same outputs serve unsigned users. The block has no clock and no state; results follow the inputs within the same cycle.

Top module: `sat_addsub`

## Requirements
- R1: With `sub_en`=0, `sum_o` is the low `DATA_W` bits of A + B + `carry_in`, and `carry_o` is bit `DATA_W` of that unsigned total. The bit patterns are the same whether the operands are read as signed or unsigned. Example at 5 bits: 10111 + 11101 with carry 0 gives 10100 with carry 1.
- R2: With `sub_en`=1, the block computes A + (bitwise NOT B) + 1 and ignores `carry_in`.
- R3: `ovf_o` is 1 exactly when the carry into the most significant bit differs from the carry out of it. The check uses the effective second operand, which is B when adding and NOT B when subtracting.
- R4: With `sat_en`=1 and an overflow, `sat_o` is 2^(DATA_W-1)-1 when both effective operands are non-negative. Otherwise it is -2^(DATA_W-1). Example at 8 bits: 126 + 4 gives 127.
- R5: When there is no overflow, `sat_o` equals `sum_o` whatever the value of `sat_en`. Example: -1 + 3 gives 2.
- R6: With `sat_en`=0, `sat_o` equals `sum_o`, which is the wrapped result.
- R7: An operand narrower than `DATA_W` (`A_W` or `B_W` below `DATA_W`) is widened by replicating its most significant bit, not by padding with zeros.
- R8: `lt_o` and `gt_o` use signed ordering of the widened operands, so -2 is less than +1. Exactly one of `lt_o`, `gt_o` and `eq_o` is 1.
- R9: `eq_o` is 1 only when every bit of the widened A matches the widened B.
- R10: `min_o` is the signed smaller of the widened operands and `max_o` is the signed larger one. When they are equal, both outputs equal that value.
- R11: The default parameters give a 16-bit datapath with both operands 16 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | A_W | First operand, two's complement |
| b_in | input | B_W | Second operand, two's complement |
| sub_en | input | 1 | 1 selects A minus B |
| carry_in | input | 1 | Carry into bit 0 when adding |
| sat_en | input | 1 | 1 enables clamping on overflow |
| sum_o | output | DATA_W | Wrapped sum or difference |
| carry_o | output | 1 | Raw carry out of the top bit |
| ovf_o | output | 1 | Signed overflow |
| sat_o | output | DATA_W | Clamped result |
| lt_o | output | 1 | A less than B, signed |
| gt_o | output | 1 | A greater than B, signed |
| eq_o | output | 1 | A equal to B |
| min_o | output | DATA_W | Signed minimum of A and B |
| max_o | output | DATA_W | Signed maximum of A and B |

## Verification
The assertions are immediate checks evaluated whenever the inputs settle. They assume every input bit is a known 0 or 1, and each check is skipped while any input is unknown. They also assume that no operand is wider than `DATA_W`. The bench instances keep to both assumptions: every operand width is at most the result width, and every input is driven to a defined value before the first sample.

// File: rtl/sat_addsub_pkg.sv
package sat_addsub_pkg;

  typedef enum logic [1:0] {
    ORD_LT = 2'd0,
    ORD_EQ = 2'd1,
    ORD_GT = 2'd2
  } order_e;

endpackage

// File: rtl/sign_widen.sv
module sign_widen #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  d_i,
  output logic [OUT_W-1:0] d_o
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W <= 0) begin : g_same
      assign d_o = d_i[OUT_W-1:0];
    end else begin : g_pad
      // R7: copy the sign bit into every added position
      assign d_o = {{PAD_W{d_i[IN_W-1]}}, d_i};
    end
  endgenerate
endmodule

// File: rtl/ripple_core.sv
module ripple_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c0_i,
  output logic [W-1:0] s_o,
  output logic         c_msb_o,
  output logic         c_out_o
);
  logic [W-1:0] s_v;
  logic         c_top_in;
  logic         c_fin;

  always_comb begin
    logic c;
    c        = c0_i;
    c_top_in = 1'b0;
    s_v      = '0;
    for (int i = 0; i < W; i++) begin
      if (i == W - 1) c_top_in = c;
      s_v[i] = x_i[i] ^ y_i[i] ^ c;
      c      = (x_i[i] & y_i[i]) | (c & (x_i[i] ^ y_i[i]));
    end
    c_fin = c;
  end

  assign s_o     = s_v;
  assign c_msb_o = c_top_in;
  assign c_out_o = c_fin;

  always_comb begin
    if (!$isunknown({x_i, y_i, c0_i})) begin
      AST_RAW_TOTAL: assert ({c_out_o, s_o} == ({1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, c0_i})); // R1
    end
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int W = 16
) (
  input  logic [W-1:0] sum_i,
  input  logic         x_sign_i,
  input  logic         c_msb_i,
  input  logic         c_out_i,
  input  logic         sat_en_i,
  output logic         ovf_o,
  output logic [W-1:0] sat_o
);
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  assign ovf_o = c_msb_i ^ c_out_i;

  always_comb begin
    if (sat_en_i && ovf_o) sat_o = x_sign_i ? MIN_V : MAX_V;
    else                   sat_o = sum_i;
  end

  always_comb begin
    if (!$isunknown({sum_i, x_sign_i, c_msb_i, c_out_i, sat_en_i})) begin
      AST_NO_OVERFLOW: assert (ovf_o || sat_o == sum_i); // R5
      AST_SAT_OFF: assert (sat_en_i || sat_o == sum_i); // R6
      AST_SAT_RAIL: assert (!(sat_en_i && ovf_o) || sat_o == MAX_V || sat_o == MIN_V); // R4
    end
  end
endmodule

// File: rtl/signed_order.sv
module signed_order
  import sat_addsub_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         lt_o,
  output logic         gt_o,
  output logic         eq_o,
  output logic [W-1:0] min_o,
  output logic [W-1:0] max_o
);
  order_e ord;

  always_comb begin
    if (a_i == b_i)                     ord = ORD_EQ;
    else if ($signed(a_i) < $signed(b_i)) ord = ORD_LT;
    else                                ord = ORD_GT;
  end

  assign lt_o  = (ord == ORD_LT);
  assign gt_o  = (ord == ORD_GT);
  assign eq_o  = (ord == ORD_EQ);
  assign min_o = (ord == ORD_GT) ? b_i : a_i;
  assign max_o = (ord == ORD_GT) ? a_i : b_i;

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      AST_ORDER_ONEHOT: assert ($onehot({lt_o, gt_o, eq_o})); // R8
      AST_MIN_LE_MAX: assert ($signed(min_o) <= $signed(max_o)); // R10
      AST_EQ_BITS: assert (eq_o == (min_o == max_o)); // R9
    end
  end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int DATA_W = 16,
  parameter int A_W    = 16,
  parameter int B_W    = 16
) (
  input  logic [A_W-1:0]    a_in,
  input  logic [B_W-1:0]    b_in,
  input  logic              sub_en,
  input  logic              carry_in,
  input  logic              sat_en,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic [DATA_W-1:0] sat_o,
  output logic              lt_o,
  output logic              gt_o,
  output logic              eq_o,
  output logic [DATA_W-1:0] min_o,
  output logic [DATA_W-1:0] max_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] a_w, b_w, b_eff;
  logic              c0, c_msb;

  sign_widen #(.IN_W(A_W), .OUT_W(DATA_W)) u_wa (.d_i(a_in), .d_o(a_w));
  sign_widen #(.IN_W(B_W), .OUT_W(DATA_W)) u_wb (.d_i(b_in), .d_o(b_w));

  // R2: subtraction adds the inverse of B with a forced carry of one
  assign b_eff = sub_en ? ~b_w : b_w;
  assign c0    = sub_en ? 1'b1 : carry_in;

  ripple_core #(.W(DATA_W)) u_core (
    .x_i(a_w), .y_i(b_eff), .c0_i(c0),
    .s_o(sum_o), .c_msb_o(c_msb), .c_out_o(carry_o)
  );

  sat_clamp #(.W(DATA_W)) u_clamp (
    .sum_i(sum_o), .x_sign_i(a_w[MSB]), .c_msb_i(c_msb), .c_out_i(carry_o),
    .sat_en_i(sat_en), .ovf_o(ovf_o), .sat_o(sat_o)
  );

  signed_order #(.W(DATA_W)) u_ord (
    .a_i(a_w), .b_i(b_w), .lt_o(lt_o), .gt_o(gt_o), .eq_o(eq_o),
    .min_o(min_o), .max_o(max_o)
  );

  always_comb begin
    if (!$isunknown({a_in, b_in, sub_en, carry_in, sat_en})) begin
      AST_OVF_SIGNS: assert (!ovf_o || (a_w[MSB] == b_eff[MSB] && sum_o[MSB] != a_w[MSB])); // R3
      AST_WIDEN_SIGN: assert (b_w[MSB] == b_in[B_W-1] && a_w[MSB] == a_in[A_W-1]); // R7
    end
  end
endmodule

// File: tb/tb_sat_addsub.sv
module tb_sat_addsub;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // dut: 8-bit result, 4-bit second operand
  logic [7:0] a8;
  logic [3:0] b4;
  logic sub8, cin8, sen8;
  logic [7:0] sum8, sat8, min8, max8;
  logic cout8, ovf8, lt8, gt8, eq8;

  sat_addsub #(.DATA_W(8), .A_W(8), .B_W(4)) dut (
    .a_in(a8), .b_in(b4), .sub_en(sub8), .carry_in(cin8), .sat_en(sen8),
    .sum_o(sum8), .carry_o(cout8), .ovf_o(ovf8), .sat_o(sat8),
    .lt_o(lt8), .gt_o(gt8), .eq_o(eq8), .min_o(min8), .max_o(max8)
  );

  logic [4:0] a5, b5;
  logic cin5;
  logic [4:0] sum5, sat5, min5, max5;
  logic cout5, ovf5, lt5, gt5, eq5;

  sat_addsub #(.DATA_W(5), .A_W(5), .B_W(5)) dut5 (
    .a_in(a5), .b_in(b5), .sub_en(1'b0), .carry_in(cin5), .sat_en(1'b1),
    .sum_o(sum5), .carry_o(cout5), .ovf_o(ovf5), .sat_o(sat5),
    .lt_o(lt5), .gt_o(gt5), .eq_o(eq5), .min_o(min5), .max_o(max5)
  );

  logic [15:0] a16, b16;
  logic sen16;
  logic [15:0] sum16, sat16, min16, max16;
  logic cout16, ovf16, lt16, gt16, eq16;

  sat_addsub dut16 (
    .a_in(a16), .b_in(b16), .sub_en(1'b0), .carry_in(1'b0), .sat_en(sen16),
    .sum_o(sum16), .carry_o(cout16), .ovf_o(ovf16), .sat_o(sat16),
    .lt_o(lt16), .gt_o(gt16), .eq_o(eq16), .min_o(min16), .max_o(max16)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // a, b, sub, cin, sat_en, expected sat_o, expected ovf_o
  localparam logic [23:0] VEC [12] = '{
    {8'h7E, 4'h4, 1'b0, 1'b0, 1'b1, 8'h7F, 1'b1},
    {8'h7E, 4'h4, 1'b0, 1'b0, 1'b0, 8'h82, 1'b1},
    {8'hFF, 4'h3, 1'b0, 1'b0, 1'b1, 8'h02, 1'b0},
    {8'h80, 4'h1, 1'b1, 1'b0, 1'b1, 8'h80, 1'b1},
    {8'h80, 4'hF, 1'b0, 1'b0, 1'b1, 8'h80, 1'b1},
    {8'h64, 4'h8, 1'b1, 1'b0, 1'b1, 8'h6C, 1'b0},
    {8'h7F, 4'h0, 1'b0, 1'b1, 1'b1, 8'h7F, 1'b1},
    {8'h05, 4'h7, 1'b1, 1'b0, 1'b0, 8'hFE, 1'b0},
    {8'h05, 4'h7, 1'b1, 1'b1, 1'b0, 8'hFE, 1'b0},
    {8'hFE, 4'h1, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0},
    {8'h03, 4'h3, 1'b0, 1'b0, 1'b0, 8'h06, 1'b0},
    {8'h80, 4'h7, 1'b0, 1'b1, 1'b1, 8'h88, 1'b0}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    a8 = '0; b4 = '0; sub8 = 0; cin8 = 0; sen8 = 0;
    a5 = '0; b5 = '0; cin5 = 0; a16 = '0; b16 = '0; sen16 = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // reset state: all-zero inputs give zero sum and equality
    check("R1 idle sum", 32'(sum8), 32'h0);
    check("R9 idle eq", 32'(eq8), 32'h1);

    for (int k = 0; k < 12; k++) begin
      int av, bv, bu, eff, raw, exact, clampv;
      @(negedge clk);
      {a8, b4, sub8, cin8, sen8} = VEC[k][23:9];
      #2;
      av = a8[7] ? int'(a8) - 256 : int'(a8);
      bv = b4[3] ? int'(b4) - 16 : int'(b4);
      bu = (bv + 256) % 256;
      eff = sub8 ? (255 - bu) : bu;
      raw = int'(a8) + eff + (sub8 ? 1 : int'(cin8));
      exact = sub8 ? av - bv : av + bv + int'(cin8);
      clampv = exact > 127 ? 127 : (exact < -128 ? -128 : exact);
      check("R1 R2 R7 sum", 32'(sum8), 32'(raw % 256));
      check("R1 R2 carry", 32'(cout8), 32'(raw / 256));
      check("R3 ovf table", 32'(ovf8), 32'(VEC[k][0]));
      check("R3 ovf model", 32'(ovf8), 32'((exact > 127) || (exact < -128)));
      check("R4 R5 R6 sat table", 32'(sat8), 32'(VEC[k][8:1]));
      check("R4 R5 R6 sat model", 32'(sat8),
            sen8 ? 32'((clampv + 256) % 256) : 32'(raw % 256));
      check("R8 lt", 32'(lt8), 32'(av < bv));
      check("R8 gt", 32'(gt8), 32'(av > bv));
      check("R9 eq", 32'(eq8), 32'(av == bv));
      check("R10 min", 32'(min8), 32'(av < bv ? int'(a8) : bu));
      check("R10 max", 32'(max8), 32'(av < bv ? bu : int'(a8)));
    end

    // R1: 5-bit pattern shared by signed and unsigned readings
    @(negedge clk); a5 = 5'b10111; b5 = 5'b11101; cin5 = 0; #2;
    check("R1 5b sum", 32'(sum5), 32'h14);
    check("R1 5b carry", 32'(cout5), 32'h1);
    check("R3 5b no ovf", 32'(ovf5), 32'h0);
    check("R8 5b lt", 32'(lt5), 32'h1);
    @(negedge clk); a5 = 5'b00001; b5 = 5'b10000; #2;
    check("R1 5b sum2", 32'(sum5), 32'h11);
    check("R1 5b carry2", 32'(cout5), 32'h0);
    check("R8 5b gt", 32'(gt5), 32'h1);

    // R11 default 16-bit; R5 -1 + 3 with and without saturation
    @(negedge clk); a16 = 16'hFFFF; b16 = 16'h0003; sen16 = 0; #2;
    check("R11 R5 sum16", 32'(sat16), 32'h0002);
    check("R11 carry16", 32'(cout16), 32'h1);
    @(negedge clk); sen16 = 1; #2;
    check("R5 sat16 on", 32'(sat16), 32'h0002);
    check("R11 R10 min16", 32'(min16), 32'hFFFF);
    @(negedge clk); a16 = 16'h7FFF; b16 = 16'h0001; #2;
    check("R4 sat16 pos", 32'(sat16), 32'h7FFF);
    check("R11 wrap16", 32'(sum16), 32'h8000);
    @(negedge clk); a16 = 16'h1234; b16 = 16'h1234; #2;
    check("R9 eq16", 32'(eq16), 32'h1);
    check("R8 lt16 off", 32'({lt16, gt16}), 32'h0);
    check("R3 ovf16 off", 32'(ovf16), 32'h0);
    check("R10 max16 tie", 32'(max16), 32'h1234);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule